// File: doc/BRIEF.md
# Timer Register Bridge for a Slow Asynchronous Count Clock

This block is an 8-bit timer/counter whose counting logic runs from a slow clock (a 32.768 kHz watch crystal or a clock on an external pin, selected upstream of the `tclk` input). Its programming interface runs on the system clock. Five timer registers are written from the system side: the counter, two compare values, a waveform-mode control and a clock-select control. Each write first lands in a system-side holding register and then crosses into the timer domain through a toggle handshake. The new value takes effect on the second timer-clock rising edge after the write.

A status register is read and written without delay. It shows one busy flag for every transfer still in flight. It also holds a sticky error bit, which records any write that was refused because its register was still busy. A separate prescaler-control register holds the timer-domain prescaler in reset. Its clear bit is kept set while the hold bit is set, and it clears itself once the hold bit is released. The counter value read by the system side is a snapshot. It is fetched continuously from the timer domain over the same kind of handshake.

Top module: `tmr_async_bridge`

## Requirements
- R1: Register addresses are CNT=0, CMPA=1, CMPB=2, CTLA=3, CTLB=4, STAT=5, PSC=6. A write to addresses 0-4 whose busy flag is clear is accepted. Its busy flag is readable as set in STAT on the next system cycle. STAT bit 0 belongs to CNT, bit 1 to CMPA, bit 2 to CMPB, bit 3 to CTLA and bit 4 to CTLB.
- R2: An accepted write changes the timer-domain register on the second rising edge of `tclk` after the write, and not on the first.
- R3: A busy flag stays set through the first `tclk` edge after its write. It clears within a few system cycles of the second edge.
- R4: A write to a register whose busy flag is set is dropped. It sets STAT bit 7, which stays set until STAT is written with bit 7 equal to 1.
- R5: Reading CNT returns the timer-domain counter as captured through the synchronizer. With the counter stopped, it returns the last written count.
- R6: With CTLB bits [2:0]=1 the counter advances once per `tclk` edge and wraps from 255 to 0.
- R7: CTLA bits [1:0] select the mode: 0 normal, 1 PWM, 2 clear-on-compare-A, 3 behaves as normal. In PWM mode `cmp_x_o` is (count < compare). In the other modes it is (count == compare).
- R8: In PWM mode a new compare value becomes effective only when the counter wraps from 255. In the other modes it is effective as soon as it lands.
- R9: In clear-on-compare-A mode, a counting tick taken while the count equals compare A loads 0 instead of count+1.
- R10: CTLB bits [2:0] select stop (0) or a division of `tclk` by 1, 8, 32, 64, 128, 256 or 1024 (codes 1-7). With code 2, after the prescaler leaves reset, the first tick falls on the eighth `tclk` edge after the one that clears it, and later ticks follow every eighth edge.
- R11: PSC bit 0 is hold and bit 1 is clear. While clear is set, the prescaler is held at zero and the counter does not advance for any select code. Clear stays set while hold is set. With hold at 0, clear drops by itself once the timer domain has seen it.
- R12: Reading CMPA, CMPB, CTLA or CTLB returns the last accepted value, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock for the register interface |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| tclk | input | 1 | Asynchronous timer clock |
| cmp_a_o | output | 1 | Compare A output |
| cmp_b_o | output | 1 | Compare B output |

## Verification
A wrong handshake state shows up in two ways. A busy flag may never clear, or a write may land one `tclk` edge early or late. The compare outputs reveal the landing edge within one timer period, and the STAT read reveals the stuck flag a few system cycles later. A broken buffer, prescaler or clear-mode state does not show at once. It appears as a wrong stopped-count readback or a wrong compare level, after an exactly counted number of `tclk` edges.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  parameter int unsigned NREG   = 5;
  parameter int unsigned MODE_W = 2;
  parameter int unsigned SEL_W  = 3;

  typedef enum logic [2:0] {
    RA_CNT  = 3'd0,
    RA_CMPA = 3'd1,
    RA_CMPB = 3'd2,
    RA_CTLA = 3'd3,
    RA_CTLB = 3'd4,
    RA_STAT = 3'd5,
    RA_PSC  = 3'd6
  } reg_addr_e;

  typedef enum logic [MODE_W-1:0] {
    WM_NORMAL = 2'd0,
    WM_PWM    = 2'd1,
    WM_CLR_A  = 2'd2
  } wave_mode_e;

  // log2 of the division ratio picked by a clock-select code
  function automatic int unsigned div_shift(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd2:    return 3;
      3'd3:    return 5;
      3'd4:    return 6;
      3'd5:    return 7;
      3'd6:    return 8;
      3'd7:    return 10;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) stage_q <= 2'b00;
    else           stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_out = stage_q[1];
endmodule

// File: rtl/tmr_bit_sync.sv
module tmr_bit_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [1:0] ff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= 2'b00;
    else        ff_q <= {ff_q[0], d};
  end

  assign q = ff_q[1];
endmodule

// File: rtl/tmr_word_xfer.sv
// Toggle handshake: the source holds a word and flips req; the destination
// detects the flip after its synchronizer and loads the held word.
module tmr_word_xfer #(
  parameter int unsigned W = 8
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic         src_go,
  input  logic [W-1:0] src_data,
  output logic         src_busy,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic         dst_load,
  output logic [W-1:0] dst_data
);
  logic [W-1:0] hold_q, hold_d;
  logic         req_q, req_d;
  logic [1:0]   ack_sync_q;
  logic [1:0]   req_sync_q;

  assign src_busy = req_q ^ ack_sync_q[1];

  always_comb begin
    hold_d = hold_q;
    req_d  = req_q;
    if (src_go && !src_busy) begin
      hold_d = src_data;
      req_d  = ~req_q;
    end
  end

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      hold_q     <= '0;
      req_q      <= 1'b0;
      ack_sync_q <= 2'b00;
    end else begin
      hold_q     <= hold_d;
      req_q      <= req_d;
      ack_sync_q <= {ack_sync_q[0], req_sync_q[1]};
    end
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) req_sync_q <= 2'b00;
    else            req_sync_q <= {req_sync_q[0], req_q};
  end

  // flip seen between the two stages: consumer loads on the second edge
  assign dst_load = req_sync_q[0] ^ req_sync_q[1];
  assign dst_data = hold_q;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int unsigned PW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick,
  output logic [PW-1:0]    cnt
);
  logic [PW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] mask;

  always_comb begin
    mask = {PW{1'b1}} >> (PW - div_shift(sel));
    tick = (sel != '0) && !clr && ((cnt_q & mask) == mask);
    cnt_d = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned PSC_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREG-1:0]   ld,
  input  logic [DW-1:0]     cnt_in,
  input  logic [DW-1:0]     cmpa_in,
  input  logic [DW-1:0]     cmpb_in,
  input  logic [MODE_W-1:0] mode_in,
  input  logic [SEL_W-1:0]  sel_in,
  input  logic              psc_clr,
  output logic [DW-1:0]     cnt_o,
  output logic [PSC_W-1:0]  psc_cnt_o,
  output logic              cmp_a_o,
  output logic              cmp_b_o
);
  localparam int unsigned NCH = 2;

  logic [DW-1:0]     cnt_q, cnt_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic              tick, wrap, is_pwm, is_clr;
  logic [NCH-1:0][DW-1:0] cmp_in, buf_q, eff_q;
  logic [NCH-1:0]    ch_ld, hit;

  tmr_prescaler #(.PW(PSC_W)) u_psc (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (psc_clr),
    .sel  (sel_q),
    .tick (tick),
    .cnt  (psc_cnt_o)
  );

  assign is_pwm = (mode_q == WM_PWM);
  assign is_clr = (mode_q == WM_CLR_A);
  assign wrap   = tick && (cnt_q == '1);
  assign cmp_in = {cmpb_in, cmpa_in};
  assign ch_ld  = {ld[RA_CMPB], ld[RA_CMPA]};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [DW-1:0] buf_d, eff_d;
    always_comb begin
      buf_d = ch_ld[ch] ? cmp_in[ch] : buf_q[ch];
      if (!is_pwm || wrap) eff_d = buf_d;
      else                 eff_d = eff_q[ch];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        buf_q[ch] <= '0;
        eff_q[ch] <= '0;
      end else begin
        buf_q[ch] <= buf_d;
        eff_q[ch] <= eff_d;
      end
    end
    assign hit[ch] = is_pwm ? (cnt_q < eff_q[ch]) : (cnt_q == eff_q[ch]);
  end

  always_comb begin
    cnt_d  = cnt_q;
    mode_d = ld[RA_CTLA] ? mode_in : mode_q;
    sel_d  = ld[RA_CTLB] ? sel_in : sel_q;
    if (ld[RA_CNT]) begin
      cnt_d = cnt_in;
    end else if (tick) begin
      if (is_clr && (cnt_q == eff_q[0])) cnt_d = '0;
      else                               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mode_q <= '0;
      sel_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
      sel_q  <= sel_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign cmp_a_o = hit[0];
  assign cmp_b_o = hit[1];
endmodule

// File: rtl/tmr_async_bridge.sv
module tmr_async_bridge
  import tmr_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned PSC_W = 10
) (
  input  logic          clk_sys,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          tclk,
  output logic          cmp_a_o,
  output logic          cmp_b_o
);
  localparam int unsigned PADW = DW - 1 - NREG;

  logic srst_n, trst_n;
  logic [NREG-1:0] wr_go, reg_busy, ld_t;
  logic [DW-1:0] cnt_hold, cmpa_hold, cmpb_hold;
  logic [MODE_W-1:0] ctla_hold;
  logic [SEL_W-1:0]  ctlb_hold;
  logic err_q, err_d;
  logic psc_hold_q, psc_hold_d, psc_clr_q, psc_clr_d;
  logic psc_rst_t, psc_ack_s;
  logic [DW-1:0] cnt_t, rb_data, cnt_rd_q, cnt_rd_d;
  logic rb_busy, rb_load;
  logic [PSC_W-1:0] psc_cnt_t;
  logic [DW-1:0] stat_word;

  tmr_rst_sync u_rs_sys (.clk(clk_sys), .rst_n_in(rst_n), .rst_n_out(srst_n));
  tmr_rst_sync u_rs_tmr (.clk(tclk),    .rst_n_in(rst_n), .rst_n_out(trst_n));

  always_comb begin
    for (int i = 0; i < NREG; i++) wr_go[i] = wr_en && (wr_addr == 3'(i));
  end

  tmr_word_xfer #(.W(DW)) u_x_cnt (
    .src_clk(clk_sys), .src_rst_n(srst_n), .src_go(wr_go[RA_CNT]), .src_data(wr_data),
    .src_busy(reg_busy[RA_CNT]), .dst_clk(tclk), .dst_rst_n(trst_n),
    .dst_load(ld_t[RA_CNT]), .dst_data(cnt_hold));

  tmr_word_xfer #(.W(DW)) u_x_cmpa (
    .src_clk(clk_sys), .src_rst_n(srst_n), .src_go(wr_go[RA_CMPA]), .src_data(wr_data),
    .src_busy(reg_busy[RA_CMPA]), .dst_clk(tclk), .dst_rst_n(trst_n),
    .dst_load(ld_t[RA_CMPA]), .dst_data(cmpa_hold));

  tmr_word_xfer #(.W(DW)) u_x_cmpb (
    .src_clk(clk_sys), .src_rst_n(srst_n), .src_go(wr_go[RA_CMPB]), .src_data(wr_data),
    .src_busy(reg_busy[RA_CMPB]), .dst_clk(tclk), .dst_rst_n(trst_n),
    .dst_load(ld_t[RA_CMPB]), .dst_data(cmpb_hold));

  tmr_word_xfer #(.W(MODE_W)) u_x_ctla (
    .src_clk(clk_sys), .src_rst_n(srst_n), .src_go(wr_go[RA_CTLA]),
    .src_data(wr_data[MODE_W-1:0]), .src_busy(reg_busy[RA_CTLA]), .dst_clk(tclk),
    .dst_rst_n(trst_n), .dst_load(ld_t[RA_CTLA]), .dst_data(ctla_hold));

  tmr_word_xfer #(.W(SEL_W)) u_x_ctlb (
    .src_clk(clk_sys), .src_rst_n(srst_n), .src_go(wr_go[RA_CTLB]),
    .src_data(wr_data[SEL_W-1:0]), .src_busy(reg_busy[RA_CTLB]), .dst_clk(tclk),
    .dst_rst_n(trst_n), .dst_load(ld_t[RA_CTLB]), .dst_data(ctlb_hold));

  // counter snapshot travels the other way, restarted as soon as idle
  tmr_word_xfer #(.W(DW)) u_x_rb (
    .src_clk(tclk), .src_rst_n(trst_n), .src_go(!rb_busy), .src_data(cnt_t),
    .src_busy(rb_busy), .dst_clk(clk_sys), .dst_rst_n(srst_n),
    .dst_load(rb_load), .dst_data(rb_data));

  tmr_bit_sync u_bs_clr (.clk(tclk),    .rst_n(trst_n), .d(psc_clr_q), .q(psc_rst_t));
  tmr_bit_sync u_bs_ack (.clk(clk_sys), .rst_n(srst_n), .d(psc_rst_t), .q(psc_ack_s));

  tmr_core #(.DW(DW), .PSC_W(PSC_W)) u_core (
    .clk      (tclk),
    .rst_n    (trst_n),
    .ld       (ld_t),
    .cnt_in   (cnt_hold),
    .cmpa_in  (cmpa_hold),
    .cmpb_in  (cmpb_hold),
    .mode_in  (ctla_hold),
    .sel_in   (ctlb_hold),
    .psc_clr  (psc_rst_t),
    .cnt_o    (cnt_t),
    .psc_cnt_o(psc_cnt_t),
    .cmp_a_o  (cmp_a_o),
    .cmp_b_o  (cmp_b_o)
  );

  // system-side next state
  always_comb begin
    err_d      = err_q;
    psc_hold_d = psc_hold_q;
    psc_clr_d  = psc_clr_q;
    cnt_rd_d   = rb_load ? rb_data : cnt_rd_q;
    if (wr_en && (wr_addr == RA_STAT) && wr_data[DW-1]) err_d = 1'b0;
    if (|(wr_go & reg_busy)) err_d = 1'b1;
    if (wr_en && (wr_addr == RA_PSC)) begin
      psc_hold_d = wr_data[0];
      psc_clr_d  = wr_data[1];
    end else if (psc_clr_q && !psc_hold_q && psc_ack_s) begin
      psc_clr_d = 1'b0;
    end
  end

  always_ff @(posedge clk_sys or negedge srst_n) begin
    if (!srst_n) begin
      err_q      <= 1'b0;
      psc_hold_q <= 1'b0;
      psc_clr_q  <= 1'b0;
      cnt_rd_q   <= '0;
    end else begin
      err_q      <= err_d;
      psc_hold_q <= psc_hold_d;
      psc_clr_q  <= psc_clr_d;
      cnt_rd_q   <= cnt_rd_d;
    end
  end

  assign stat_word = {err_q, {PADW{1'b0}}, reg_busy};

  always_comb begin
    case (rd_addr)
      RA_CNT:  rd_data = cnt_rd_q;
      RA_CMPA: rd_data = cmpa_hold;
      RA_CMPB: rd_data = cmpb_hold;
      RA_CTLA: rd_data = DW'(ctla_hold);
      RA_CTLB: rd_data = DW'(ctlb_hold);
      RA_STAT: rd_data = stat_word;
      RA_PSC:  rd_data = DW'({psc_clr_q, psc_hold_q});
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tmr_async_bridge_chk.sv
module tmr_async_bridge_chk
  import tmr_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned PSC_W = 10
) (
  input logic             clk_sys,
  input logic             srst_n,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [DW-1:0]    wr_data,
  input logic [NREG-1:0]  reg_busy,
  input logic             err_q,
  input logic [DW-1:0]    cmpa_hold,
  input logic             psc_hold_q,
  input logic             psc_clr_q,
  input logic             tclk,
  input logic             trst_n,
  input logic             psc_rst_t,
  input logic [PSC_W-1:0] psc_cnt_t
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk_sys) disable iff (!srst_n)
      (wr_en && wr_addr == 3'(i) && !reg_busy[i]) |=> reg_busy[i]); // R1
    AST_BUSY_WRITE_ERR: assert property (@(posedge clk_sys) disable iff (!srst_n)
      (wr_en && wr_addr == 3'(i) && reg_busy[i]) |=> err_q); // R4
  end

  AST_ERR_STICKY: assert property (@(posedge clk_sys) disable iff (!srst_n)
    (err_q && !(wr_en && wr_addr == RA_STAT && wr_data[DW-1])) |=> err_q); // R4

  AST_HOLD_STABLE_BUSY: assert property (@(posedge clk_sys) disable iff (!srst_n)
    reg_busy[RA_CMPA] |=> (!reg_busy[RA_CMPA] || $stable(cmpa_hold))); // R12

  AST_CLR_KEPT_BY_HOLD: assert property (@(posedge clk_sys) disable iff (!srst_n)
    (psc_hold_q && psc_clr_q && !(wr_en && wr_addr == RA_PSC)) |=> psc_clr_q); // R11

  AST_PSC_HELD_ZERO: assert property (@(posedge tclk) disable iff (!trst_n)
    psc_rst_t |=> (psc_cnt_t == '0)); // R11
endmodule

bind tmr_async_bridge tmr_async_bridge_chk #(.DW(DW), .PSC_W(PSC_W)) u_chk (
  .clk_sys   (clk_sys),
  .srst_n    (srst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .reg_busy  (reg_busy),
  .err_q     (err_q),
  .cmpa_hold (cmpa_hold),
  .psc_hold_q(psc_hold_q),
  .psc_clr_q (psc_clr_q),
  .tclk      (tclk),
  .trst_n    (trst_n),
  .psc_rst_t (psc_rst_t),
  .psc_cnt_t (psc_cnt_t)
);

// File: tb/sim_tmr_async_bridge.sv
module sim_tmr_async_bridge;
  localparam logic [2:0] A_CNT = 3'd0, A_CMPA = 3'd1, A_CMPB = 3'd2, A_CTLA = 3'd3,
                         A_CTLB = 3'd4, A_STAT = 3'd5, A_PSC = 3'd6;

  logic clk = 1'b0, tclk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic cmp_a_o, cmp_b_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always #73 tclk = ~tclk;

  tmr_async_bridge u0 (
    .clk_sys(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tclk(tclk), .cmp_a_o(cmp_a_o), .cmp_b_o(cmp_b_o)
  );

  function automatic bit exp_cmp(input int mode, input int cnt, input int cmp);
    return (mode == 1) ? (cnt < cmp) : (cnt == cmp);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic awr(input logic [2:0] a, input logic [7:0] d);
    @(posedge tclk);
    wr(a, d);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #2 d = rd_data;
  endtask

  task automatic settle();
    logic [7:0] s;
    for (int i = 0; i < 400; i++) begin
      rd(A_STAT, s);
      if (s[4:0] == 5'd0) break;
    end
    repeat (10) @(posedge tclk);
    #5;
  endtask

  // counter runs at divide-by-one for exactly m increments
  task automatic run_edges(input int m);
    awr(A_CTLB, 8'd1);
    repeat (m) @(posedge tclk);
    wr(A_CTLB, 8'd0);
    settle();
  endtask

  initial begin
    logic [7:0] d;
    int unsigned seed;
    seed = $urandom(32'd7331);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge tclk);
    repeat (4) @(negedge clk);

    // reset state
    rd(A_STAT, d); chk("R1 reset STAT", d, 0);
    rd(A_CNT, d);  chk("R5 reset CNT", d, 0);
    rd(A_PSC, d);  chk("R11 reset PSC", d, 0);
    chk("R7 reset cmp_a", cmp_a_o, 1);

    // two-edge landing and busy flag timing
    wr(A_CNT, 8'd5); settle();
    chk("R7 cmp_b before", cmp_b_o, 0);
    awr(A_CMPB, 8'd5);
    rd(A_STAT, d); chk("R1 busy CMPB set", d[2], 1);
    @(posedge tclk); #5;
    chk("R2 not after first edge", cmp_b_o, 0);
    rd(A_STAT, d); chk("R3 busy after first edge", d[2], 1);
    @(posedge tclk); #5;
    chk("R2 lands on second edge", cmp_b_o, 1);
    repeat (6) @(posedge clk);
    rd(A_STAT, d); chk("R3 busy cleared", d[2], 0);

    // refused write while busy
    awr(A_CMPA, 8'd9);
    wr(A_CMPA, 8'd33);
    rd(A_STAT, d); chk("R4 err set", d[7], 1);
    settle();
    rd(A_CMPA, d); chk("R4 dropped write", d, 9);
    chk("R4 cmp_a uses first", cmp_a_o, 0);
    wr(A_STAT, 8'h00);
    rd(A_STAT, d); chk("R4 err sticky", d[7], 1);
    wr(A_STAT, 8'h80);
    rd(A_STAT, d); chk("R4 err cleared", d[7], 0);

    // random counts and compare values in normal mode
    for (int i = 0; i < 6; i++) begin
      logic [7:0] v, w;
      v = 8'($urandom);
      w = (i % 2 == 1) ? v : 8'($urandom);
      wr(A_CNT, v); wr(A_CMPB, w); settle();
      rd(A_CNT, d);  chk("R5 random CNT", d, v);
      rd(A_CMPB, d); chk("R12 random CMPB", d, w);
      chk("R7 random cmp_b", cmp_b_o, exp_cmp(0, v, w));
    end
    rd(A_STAT, d); chk("R4 no err from random", d[7], 0);

    // counting with wrap
    wr(A_CNT, 8'd250); settle();
    run_edges(9);
    rd(A_CNT, d); chk("R6 count and wrap", d, (250 + 9) % 256);

    // PWM double buffering
    wr(A_CMPA, 8'd20); wr(A_CTLA, 8'd1); wr(A_CNT, 8'd10); settle();
    chk("R7 pwm level", cmp_a_o, exp_cmp(1, 10, 20));
    rd(A_CTLA, d); chk("R12 CTLA read", d, 1);
    wr(A_CMPA, 8'd5); settle();
    chk("R8 held until wrap", cmp_a_o, exp_cmp(1, 10, 20));
    wr(A_CNT, 8'd255); settle();
    run_edges(8);
    rd(A_CNT, d); chk("R6 count after wrap", d, 7);
    chk("R8 new value after wrap", cmp_a_o, exp_cmp(1, 7, 5));

    // clear on compare A
    wr(A_CTLA, 8'd2); wr(A_CMPA, 8'd3); wr(A_CNT, 8'd0); settle();
    run_edges(10);
    rd(A_CNT, d); chk("R9 clear on compare", d, 10 % 4);

    // prescaler hold and divide-by-eight
    wr(A_CTLA, 8'd0); wr(A_PSC, 8'h03); wr(A_CNT, 8'd0); wr(A_CTLB, 8'd1); settle();
    repeat (20) @(posedge tclk);
    rd(A_PSC, d); chk("R11 clear kept by hold", d, 3);
    rd(A_CNT, d); chk("R11 counter held", d, 0);
    wr(A_CTLB, 8'd2); settle();
    awr(A_PSC, 8'h00);
    repeat (80) @(posedge tclk);
    wr(A_CTLB, 8'd0); settle();
    rd(A_CNT, d); chk("R10 divide by eight", d, 10);
    wr(A_PSC, 8'h02);
    repeat (20) @(posedge tclk);
    rd(A_PSC, d); chk("R11 clear self-drops", d, 0);
    rd(A_CTLB, d); chk("R12 CTLB read", d, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule